// File: doc/BRIEF.md
# Gray-Timestamp Single-Slope ADC Capture

This block is the digital back end of a single-slope converter array. One shared timestamp generator counts conversion time in bins. Each bin lasts a fixed number of clock cycles, the sub-bin steps. The generator broadcasts the bin count to every pixel channel as a Gray code. Each channel watches a one-bit comparator event. When the event arrives, the channel waits for its own trim delay, counted in sub-bin steps, and then latches the Gray code on the bus. This moves the pixel's effective offset by a fraction of a bin.

When the conversion ends, every channel turns its latched code into binary through an XOR prefix chain. It then stores the result in its own frame memory. A channel whose comparator never fired, or whose delayed capture would fall past the end of the ramp, stores the full-scale code. In extended mode the ramp runs for twice as many bins. Each channel then forms one more result bit itself, by spotting the shared counter's wrap in the Gray MSB.

Frames pile up per channel during a pulse train. They are drained between trains through a random-access read port, and conversions are refused while the drain window is open. A train-clear pulse rewinds every write pointer. A depth policy input picks whether a full memory wraps to frame 0 or stops writing. In both cases a sticky overflow flag records the excess conversion.

Top module: `ssadc_capture`

## Requirements
- R1: After reset `busy`, `start_rej`, `rd_valid` and every `overflow` bit are 0 and `ts_gray` is 0.
- R2: A start accepted at a clock edge sets `busy` from the next cycle. During cycle c after that edge (c counted from 0), `ts_gray` equals the Gray code (b XOR b>>1) of b = floor(c/SUB), and only one bit of it changes between successive busy cycles.
- R3: A comparator event sampled high at the end of cycle c, with trim t, captures the timestamp of cycle c+t. The stored result is the binary bin number floor((c+t)/SUB).
- R4: The trim is a TRIM_W-bit per-pixel count of sub-bin steps; with SUB=10 and trim 15 the capture moves by 1.5 bins. A capture that would land at or after cycle 2^N·SUB stores full scale.
- R5: A channel with no event during the conversion stores full scale: 255 in normal mode and 511 in extended mode.
- R6: Only the first event of a conversion counts. Events while no conversion runs have no effect.
- R7: With `ext_mode` high at start, the conversion lasts 512·SUB cycles and results run 0..511. Bit 8 is 1 exactly when the capture falls at or after cycle 256·SUB.
- R8: Each conversion writes one frame per channel at the channel's write pointer, starting from frame 0. With `wrap_en` high, the conversion after the last frame writes frame 0 again and sets `overflow`, which stays set.
- R9: With `wrap_en` low and the memory full, a further conversion changes no stored frame and sets `overflow`. A `train_clr` pulse while idle rewinds the pointer to frame 0 and clears `overflow`.
- R10: `rd_en` while idle gives `rd_valid` high and `rd_data` equal to frame `rd_frame` of channel `rd_pix` one cycle later. A start while `drain_mode` is high is refused: `busy` stays low and `start_rej` pulses for one cycle.
- R11: `rd_en` during a conversion produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sub-bin step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Request to start a conversion |
| ext_mode | input | 1 | Extended (one extra bit) conversion when high |
| wrap_en | input | 1 | Depth policy: 1 wraps to frame 0, 0 stops writing |
| train_clr | input | 1 | Rewind write pointers and clear overflow (idle only) |
| drain_mode | input | 1 | Readout window; starts are refused while high |
| cmp_fire | input | NPIX | Comparator event per channel |
| trim_cfg | input | NPIX*TRIM_W | Per-channel trim in sub-bin steps |
| rd_en | input | 1 | Read request |
| rd_pix | input | PW | Channel to read |
| rd_frame | input | AW | Frame to read |
| busy | output | 1 | Conversion in progress |
| ts_gray | output | CNT_W | Broadcast Gray timestamp |
| start_rej | output | 1 | One-cycle pulse for a refused start |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W+1 | Stored result |
| overflow | output | NPIX | Sticky per-channel overflow |

## Verification
The timestamp is due in the same cycle as the bin register, so the bench compares it at mid-cycle c against floor(c/SUB). A capture is due in cycle c+t, and the stored frame becomes visible once `busy` falls at cycle 2^N·SUB. The bench therefore reads results back only after the negative edge that follows that cycle. Read data, `start_rej` and the overflow flags are registered, so each is checked at the negative edge one cycle after the stimulus edge. For a refused start, `busy` is checked at that edge and again one cycle later.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    localparam int GW_MAX = 16;

    // Gray to binary: each binary bit is the XOR of all Gray bits at or above it
    function automatic logic [GW_MAX-1:0] gray_to_bin(input logic [GW_MAX-1:0] g);
        logic [GW_MAX-1:0] b;
        b[GW_MAX-1] = g[GW_MAX-1];
        for (int i = GW_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ssadc_tsgen.sv
module ssadc_tsgen #(
    parameter int CNT_W = 8,
    parameter int SUB   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             ext_mode,
    input  logic             drain_mode,
    output logic             busy,
    output logic             start_acc,
    output logic             conv_end,
    output logic             start_rej,
    output logic [CNT_W-1:0] ts_gray
);
    localparam int SW = (SUB > 1) ? $clog2(SUB) : 1;

    typedef struct packed {
        logic             busy;
        logic             ext;
        logic             hi;
        logic [SW-1:0]    sub;
        logic [CNT_W-1:0] bin;
        logic             rej;
    } st_t;

    st_t  s_q, s_d;
    logic last_tick;

    always_comb begin
        s_d       = s_q;
        start_acc = conv_start && !drain_mode && !s_q.busy;
        s_d.rej   = conv_start && drain_mode;
        last_tick = s_q.busy && (s_q.sub == SW'(SUB - 1));
        conv_end  = last_tick && (&s_q.bin) && (!s_q.ext || s_q.hi);
        if (start_acc) begin
            s_d.busy = 1'b1;
            s_d.ext  = ext_mode;
            s_d.hi   = 1'b0;
            s_d.sub  = '0;
            s_d.bin  = '0;
        end else if (s_q.busy) begin
            s_d.sub = last_tick ? '0 : s_q.sub + 1'b1;
            if (last_tick) begin
                s_d.bin = s_q.bin + 1'b1;
                if (&s_q.bin) s_d.hi = 1'b1;
            end
            if (conv_end) begin
                s_d.busy = 1'b0;
                s_d.hi   = 1'b0;
                s_d.bin  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign start_rej = s_q.rej;
    assign ts_gray   = s_q.bin ^ (s_q.bin >> 1);

    AST_REFUSE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && !busy) |=> !busy); // R10

endmodule

// File: rtl/ssadc_pixel.sv
module ssadc_pixel
    import ssadc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 4,
    parameter int FRAMES = 4,
    localparam int DW    = CNT_W + 1,
    localparam int AW    = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start_acc,
    input  logic              conv_end,
    input  logic [CNT_W-1:0]  ts_gray,
    input  logic              fire,
    input  logic [TRIM_W-1:0] trim,
    input  logic              wrap_en,
    input  logic              train_clr,
    input  logic [AW-1:0]     rd_frame,
    output logic [DW-1:0]     rd_word,
    output logic              overflow
);
    typedef struct packed {
        logic              cap_v;
        logic              pend;
        logic [TRIM_W-1:0] dly;
        logic              cap_hi;
        logic [CNT_W-1:0]  cap_g;
        logic              hi;
        logic              msb_prev;
        logic [AW-1:0]     wptr;
        logic              filled;
        logic              ovf;
    } st_t;

    st_t              s_q, s_d;
    logic             hi_now, cap_now, arm, we;
    logic [CNT_W-1:0] res_g;
    logic             res_hi;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    mem_q [FRAMES];

    always_comb begin
        s_d     = s_q;
        // in-pixel extra bit: shared counter wrapped when Gray MSB falls
        hi_now  = s_q.hi | (busy & s_q.msb_prev & ~ts_gray[CNT_W-1]);
        cap_now = busy && !s_q.cap_v &&
                  ((s_q.pend && s_q.dly == TRIM_W'(1)) || (!s_q.pend && fire && trim == '0));
        arm     = busy && !s_q.cap_v && !s_q.pend && fire && trim != '0;

        s_d.msb_prev = busy & ts_gray[CNT_W-1];
        s_d.hi       = busy & hi_now;
        if (arm) begin
            s_d.pend = 1'b1;
            s_d.dly  = trim;
        end else if (s_q.pend) begin
            s_d.dly = s_q.dly - 1'b1;
        end
        if (cap_now) begin
            s_d.cap_v  = 1'b1;
            s_d.pend   = 1'b0;
            s_d.cap_hi = hi_now;
            s_d.cap_g  = ts_gray;
        end
        if (start_acc) begin
            s_d.cap_v = 1'b0;
            s_d.pend  = 1'b0;
        end

        // no capture by the end of the ramp: the live code is full scale
        res_g  = s_q.cap_v ? s_q.cap_g  : ts_gray;
        res_hi = s_q.cap_v ? s_q.cap_hi : hi_now;
        wdata  = {res_hi, CNT_W'(gray_to_bin(GW_MAX'(res_g)))};
        we     = conv_end && (!s_q.filled || wrap_en);
        if (conv_end) begin
            if (s_q.filled) s_d.ovf = 1'b1;
            if (we) begin
                if (s_q.wptr == AW'(FRAMES - 1)) begin
                    s_d.filled = 1'b1;
                    s_d.wptr   = wrap_en ? '0 : s_q.wptr;
                end else begin
                    s_d.wptr = s_q.wptr + 1'b1;
                end
            end
        end
        if (train_clr && !busy) begin
            s_d.wptr   = '0;
            s_d.filled = 1'b0;
            s_d.ovf    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[s_q.wptr] <= wdata;
    end

    assign rd_word  = mem_q[rd_frame];
    assign overflow = s_q.ovf;

    AST_TS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($countones(ts_gray ^ $past(ts_gray)) <= 1)); // R2
    AST_FIRST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cap_v && !start_acc) |=> (s_q.cap_v && $stable(s_q.cap_g))); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !(train_clr && !busy)) |=> s_q.ovf); // R8
    AST_STOP_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_end && s_q.filled && !wrap_en) |=> $stable(s_q.wptr)); // R9

endmodule

// File: rtl/ssadc_capture.sv
module ssadc_capture #(
    parameter int  CNT_W  = 8,
    parameter int  SUB    = 10,
    parameter int  TRIM_W = 4,
    parameter int  NPIX   = 4,
    parameter int  FRAMES = 4,
    localparam int DW     = CNT_W + 1,
    localparam int AW     = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int PW     = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_start,
    input  logic                   ext_mode,
    input  logic                   wrap_en,
    input  logic                   train_clr,
    input  logic                   drain_mode,
    input  logic [NPIX-1:0]        cmp_fire,
    input  logic [NPIX*TRIM_W-1:0] trim_cfg,
    input  logic                   rd_en,
    input  logic [PW-1:0]          rd_pix,
    input  logic [AW-1:0]          rd_frame,
    output logic                   busy,
    output logic [CNT_W-1:0]       ts_gray,
    output logic                   start_rej,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic [NPIX-1:0]        overflow
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_t;

    logic          start_acc, conv_end;
    logic [DW-1:0] words [NPIX];
    rd_t           r_q, r_d;

    ssadc_tsgen #(.CNT_W(CNT_W), .SUB(SUB)) u_tsgen (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ext_mode(ext_mode),
        .drain_mode(drain_mode), .busy(busy), .start_acc(start_acc),
        .conv_end(conv_end), .start_rej(start_rej), .ts_gray(ts_gray)
    );

    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        ssadc_pixel #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .FRAMES(FRAMES)) u_pix (
            .clk(clk), .rst_n(rst_n), .busy(busy), .start_acc(start_acc),
            .conv_end(conv_end), .ts_gray(ts_gray), .fire(cmp_fire[i]),
            .trim(trim_cfg[i*TRIM_W +: TRIM_W]), .wrap_en(wrap_en),
            .train_clr(train_clr), .rd_frame(rd_frame), .rd_word(words[i]),
            .overflow(overflow[i])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = rd_en && !busy;
        if (rd_en && !busy) r_d.data = words[rd_pix];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.valid;
    assign rd_data  = r_q.data;

    AST_READ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !busy)); // R11

endmodule

// File: tb/ssadc_capture_tb.sv
module ssadc_capture_tb;
    localparam int CNT_W = 8, SUB = 10, TRIM_W = 4, NPIX = 4, FRAMES = 4;
    localparam int DW = CNT_W + 1, AW = 2, PW = 2;

    logic                   clk = 1'b0, rst_n = 1'b0;
    logic                   conv_start = 0, ext_mode = 0, wrap_en = 1, train_clr = 0, drain_mode = 0;
    logic [NPIX-1:0]        cmp_fire = '0;
    logic [NPIX*TRIM_W-1:0] trim_cfg = '0;
    logic                   rd_en = 0;
    logic [PW-1:0]          rd_pix = '0;
    logic [AW-1:0]          rd_frame = '0;
    logic                   busy, start_rej, rd_valid;
    logic [CNT_W-1:0]       ts_gray;
    logic [DW-1:0]          rd_data;
    logic [NPIX-1:0]        overflow;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int fire_at[NPIX], fire2_at[NPIX], trim_v[NPIX];
    logic [NPIX-1:0] pre_fire;
    int bmem[NPIX][FRAMES];
    bit bvalid[FRAMES];
    int bptr = 0;
    bit bfill = 0, bovf = 0;

    ssadc_capture #(.CNT_W(CNT_W), .SUB(SUB), .TRIM_W(TRIM_W), .NPIX(NPIX), .FRAMES(FRAMES)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ext_mode(ext_mode),
        .wrap_en(wrap_en), .train_clr(train_clr), .drain_mode(drain_mode),
        .cmp_fire(cmp_fire), .trim_cfg(trim_cfg), .rd_en(rd_en), .rd_pix(rd_pix),
        .rd_frame(rd_frame), .busy(busy), .ts_gray(ts_gray), .start_rej(start_rej),
        .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gray(input int b);
        return b ^ (b >> 1);
    endfunction

    task automatic rd_check(input int p, input int f, input int exp, input string req);
        @(negedge clk);
        rd_en = 1; rd_pix = PW'(p); rd_frame = AW'(f);
        @(negedge clk);
        rd_en = 0;
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " rd_data"}, int'(rd_data), exp);
    endtask

    task automatic check_memory(input string req);
        for (int f = 0; f < FRAMES; f++)
            if (bvalid[f])
                for (int p = 0; p < NPIX; p++) rd_check(p, f, bmem[p][f], req);
        for (int p = 0; p < NPIX; p++) chk({req, " overflow"}, int'(overflow[p]), int'(bovf));
    endtask

    // one conversion; expected results computed from R3/R4/R5/R7
    task automatic run_conv(input bit m9, input string req);
        int full, total;
        int e[NPIX];
        full  = m9 ? 512 : 256;
        total = full * SUB;
        for (int p = 0; p < NPIX; p++) begin
            trim_cfg[p*TRIM_W +: TRIM_W] = TRIM_W'(trim_v[p]);
            if (fire_at[p] >= 0 && fire_at[p] + trim_v[p] < total)
                e[p] = (fire_at[p] + trim_v[p]) / SUB;
            else
                e[p] = full - 1;
        end
        @(negedge clk);
        ext_mode = m9; conv_start = 1; cmp_fire = pre_fire;
        @(negedge clk);
        conv_start = 0;
        chk({req, " R2 busy at cycle 0"}, int'(busy), 1);
        for (int cyc = 0; cyc < total; cyc++) begin
            for (int p = 0; p < NPIX; p++)
                cmp_fire[p] = (fire_at[p] == cyc) || (fire2_at[p] == cyc);
            if (cyc == 37)   chk({req, " R2 ts at 37"}, int'(ts_gray), gray(3));
            if (cyc == 2000) chk({req, " R2 ts at 2000"}, int'(ts_gray), gray(200));
            if (cyc == 100)  rd_en = 1;
            if (cyc == 101) begin
                chk({req, " R11 no read while busy"}, int'(rd_valid), 0);
                rd_en = 0;
            end
            @(negedge clk);
        end
        cmp_fire = '0;
        chk({req, " busy low at end"}, int'(busy), 0);
        if (!bfill || wrap_en) begin
            for (int p = 0; p < NPIX; p++) bmem[p][bptr] = e[p];
            bvalid[bptr] = 1;
            if (bfill) bovf = 1;
            if (bptr == FRAMES - 1) begin
                bfill = 1;
                if (wrap_en) bptr = 0;
            end else bptr++;
        end else bovf = 1;
        check_memory(req);
    endtask

    task automatic set_pat(input int f0, input int f1, input int f2, input int f3,
                           input int t0, input int t1, input int t2, input int t3);
        fire_at = '{f0, f1, f2, f3};
        trim_v  = '{t0, t1, t2, t3};
        fire2_at = '{-1, -1, -1, -1};
        pre_fire = '0;
    endtask

    task automatic t_reset;
        chk("R1 busy", int'(busy), 0);
        chk("R1 ts_gray", int'(ts_gray), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 start_rej", int'(start_rej), 0);
        chk("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_basic;
        set_pat(0, 123, 500, -1, 0, 0, 15, 0);
        fire2_at[0] = 900;       // R6 later event ignored
        pre_fire = 4'b1000;      // R6 event before start ignored
        run_conv(0, "R3 R5 R6 basic");
    endtask

    task automatic t_ext;
        set_pat(3000, 2555, 2559, -1, 0, 9, 0, 0);
        run_conv(1, "R7 extended");
    endtask

    task automatic t_trim_edges;
        set_pat(2550, 10, 1000, 2559, 15, 3, 7, 0);
        run_conv(0, "R4 trim");
        set_pat(5, 15, 25, 35, 0, 0, 0, 0);
        run_conv(0, "R8 fill");
        set_pat(40, 50, 60, 70, 0, 0, 0, 0);
        run_conv(0, "R8 wrap");
    endtask

    task automatic t_stop;
        @(negedge clk); train_clr = 1;
        @(negedge clk); train_clr = 0;
        chk("R9 clear overflow", int'(overflow), 0);
        bptr = 0; bfill = 0; bovf = 0;
        wrap_en = 0;
        for (int k = 0; k < FRAMES; k++) begin
            set_pat(100 + k*10, 200 + k*10, 300 + k*10, 400 + k*10, k, k, k, k);
            run_conv(0, "R9 stop fill");
        end
        set_pat(1000, 1100, 1200, 1300, 0, 0, 0, 0);
        run_conv(0, "R9 stop full");
    endtask

    task automatic t_reject;
        @(negedge clk); drain_mode = 1; conv_start = 1;
        @(negedge clk); conv_start = 0;
        chk("R10 start_rej pulse", int'(start_rej), 1);
        chk("R10 busy refused", int'(busy), 0);
        @(negedge clk);
        chk("R10 busy still low", int'(busy), 0);
        chk("R10 start_rej one cycle", int'(start_rej), 0);
        rd_check(2, 3, bmem[2][3], "R10 read in drain");
        drain_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ext();
        t_trim_edges();
        t_stop();
        t_reject();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule